// File: doc/BRIEF.md
# Host Interrupt and Ready/Busy Sideband Controller

This block drives the two sideband lines that sit beside a serial peripheral slave port. Internal logic raises one-cycle event strobes. Each strobe sets its own bit in a sticky status word. The host writes an enable mask with a control command. The interrupt line is pulled low while any status bit that is also enabled is set. It stays low until the host issues a read-interrupt command. That command returns the status word and clears it.

The second line is a flow-control handshake. It comes from the fill level of the receive buffer. The line is pulled low, meaning busy, once only a few entries are free. It is released again only when enough entries have drained. The gap between the two thresholds keeps the line from toggling on every byte.

Both pins are open-drain. The block outputs a drive-low enable for each pin, so a deasserted enable reads as a released, high pin.

Top module: `hostirq_flowctl`

## Requirements
- R1: After reset the status word is zero and the mask is zero. Both drive-low enables are deasserted, so the interrupt is released and the line reads ready.
- R2: An event strobe on bit i sets status bit i on the next clock edge, whatever the mask holds.
- R3: A status bit stays set until a read-interrupt command is applied. Cycles without that command never clear it.
- R4: While the read-interrupt command is high, the status port shows the word being returned. On the next edge every bit is cleared, except bits whose event strobe is high in that same cycle; those bits stay set.
- R5: A mask write loads the mask data on the next edge. Mask bit i enables event bit i.
- R6: `irq_drive_low` is high in exactly the cycles where status AND mask is nonzero. A status bit whose mask bit is zero never pulls the line.
- R7: Writing a mask that enables an already pending status bit asserts `irq_drive_low` on the next edge. Clearing that mask bit releases the line on the next edge.
- R8: Free entries are DEPTH minus `rx_level`. When free entries are at most BUSY_FREE (default 2), `rdy_drive_low` is high after the next edge.
- R9: When free entries are at least READY_FREE (default 4), `rdy_drive_low` is low after the next edge. When the free count lies strictly between the two thresholds, the output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_strobe | input | NUM_EV | One-cycle event pulses, bit i is event i |
| mask_wr | input | 1 | Load `mask_data` into the enable mask |
| mask_data | input | NUM_EV | New enable mask |
| rdint_cmd | input | 1 | Read-interrupt command: return and clear status |
| rx_level | input | LVL_W | Receive buffer entries in use, 0 to DEPTH |
| irq_drive_low | output | 1 | Pull the interrupt pin low |
| rdy_drive_low | output | 1 | Pull the ready/busy pin low (busy) |
| status | output | NUM_EV | Sticky event status word |

## Verification
The hardest case to reach from the ports is an event strobe that lands in the same cycle as a read-interrupt command. In that cycle the status word must be returned and cleared while the new bit survives. A directed step pairs the two on purpose. Random stimulus then keeps colliding them at low rates.

The second hard case is the hysteresis band. The buffer level has to approach the middle free count from both sides. A directed walk crosses each threshold upward and downward. A clamped random walk of the level then keeps revisiting the band.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;
  // number of free slots in a buffer of the given depth
  function automatic int free_slots(input int depth, input int level);
    return depth - level;
  endfunction

  // hysteresis decision for the busy flag
  function automatic logic hyst_next(input logic busy, input int free,
                                     input int busy_free, input int ready_free);
    if (free <= busy_free) return 1'b1;
    if (free >= ready_free) return 1'b0;
    return busy;
  endfunction
endpackage

// File: rtl/hostirq_evlatch.sv
module hostirq_evlatch #(
  parameter int NUM_EV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic              mask_wr,
  input  logic [NUM_EV-1:0] mask_data,
  input  logic              rd_cmd,
  output logic [NUM_EV-1:0] status_q,
  output logic [NUM_EV-1:0] mask_q,
  output logic              irq_q
);
  logic [NUM_EV-1:0] status_nxt;
  logic [NUM_EV-1:0] mask_nxt;
  logic [NUM_EV-1:0] armed_nxt;   // pending and enabled after this edge

  always_comb begin
    status_nxt = (rd_cmd ? '0 : status_q) | ev;
    mask_nxt   = mask_wr ? mask_data : mask_q;
    armed_nxt  = status_nxt & mask_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_nxt;
      mask_q   <= mask_nxt;
      irq_q    <= |armed_nxt;
    end
  end

  // R2
  ev_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((status_q & $past(ev)) == $past(ev)));
  // R3
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R4
  rdint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && ev == '0) |=> (status_q == '0));
  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ((status_q & mask_q) != '0));
  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & mask_q) != '0) |-> irq_q);
  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_data)));
endmodule

// File: rtl/hostirq_rdyhyst.sv
module hostirq_rdyhyst
  import hostirq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int BUSY_FREE  = 2,
  parameter int READY_FREE = 4,
  parameter int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  output logic             busy_q
);
  int   free_now;
  logic go_busy;
  logic go_ready;
  logic busy_nxt;

  always_comb begin
    free_now = free_slots(DEPTH, int'(level));
    go_busy  = (free_now <= BUSY_FREE);
    go_ready = (free_now >= READY_FREE);
    busy_nxt = hyst_next(busy_q, free_now, BUSY_FREE, READY_FREE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_nxt;
  end

  initial begin
    thresh_order_chk: assert (READY_FREE > BUSY_FREE);
  end

  // R8
  busy_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_busy |=> busy_q);
  // R9
  busy_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_ready |=> !busy_q);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_busy && !go_ready) |=> $stable(busy_q));
  // R8
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);
endmodule

// File: rtl/hostirq_flowctl.sv
module hostirq_flowctl #(
  parameter int NUM_EV     = 4,
  parameter int DEPTH      = 16,
  parameter int BUSY_FREE  = 2,
  parameter int READY_FREE = 4,
  parameter int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_strobe,
  input  logic              mask_wr,
  input  logic [NUM_EV-1:0] mask_data,
  input  logic              rdint_cmd,
  input  logic [LVL_W-1:0]  rx_level,
  output logic              irq_drive_low,
  output logic              rdy_drive_low,
  output logic [NUM_EV-1:0] status
);
  logic [NUM_EV-1:0] mask_q;
  logic              irq_q;
  logic              busy_q;

  hostirq_evlatch #(.NUM_EV(NUM_EV)) u_evlatch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev_strobe),
    .mask_wr   (mask_wr),
    .mask_data (mask_data),
    .rd_cmd    (rdint_cmd),
    .status_q  (status),
    .mask_q    (mask_q),
    .irq_q     (irq_q)
  );

  hostirq_rdyhyst #(
    .DEPTH      (DEPTH),
    .BUSY_FREE  (BUSY_FREE),
    .READY_FREE (READY_FREE),
    .LVL_W      (LVL_W)
  ) u_rdyhyst (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (rx_level),
    .busy_q (busy_q)
  );

  assign irq_drive_low = irq_q;
  assign rdy_drive_low = busy_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_drive_low && !rdy_drive_low && status == '0 && mask_q == '0));
  // R7
  unmask_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !rdint_cmd && ((status & mask_data) != '0)) |=> irq_drive_low);
endmodule

// File: tb/hostirq_flowctl_tb.sv
module hostirq_flowctl_tb;
  localparam int NEV   = 4;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic [NEV-1:0] ev_strobe, mask_data, status;
  logic           mask_wr, rdint_cmd, irq_drive_low, rdy_drive_low;
  logic [LW-1:0]  rx_level;

  hostirq_flowctl u_dut (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .mask_wr(mask_wr),
    .mask_data(mask_data), .rdint_cmd(rdint_cmd), .rx_level(rx_level),
    .irq_drive_low(irq_drive_low), .rdy_drive_low(rdy_drive_low), .status(status)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [NEV-1:0] m_st, m_mask;
  logic           m_busy;

  function automatic logic [NEV-1:0] f_status(logic [NEV-1:0] st, logic [NEV-1:0] ev, logic rd);
    logic [NEV-1:0] kept;
    kept = rd ? '0 : st;
    return kept | ev;
  endfunction

  function automatic logic f_busy(logic b, int lvl);
    int fr;
    fr = DEPTH - lvl;
    if (fr <= 2) return 1'b1;
    if (fr >= 4) return 1'b0;
    return b;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [NEV-1:0] ev, logic mw, logic [NEV-1:0] md, logic rd, int lvl);
    @(negedge clk);
    ev_strobe = ev; mask_wr = mw; mask_data = md; rdint_cmd = rd; rx_level = LW'(lvl);
  endtask

  task automatic tick();
    @(posedge clk);
    m_st   = f_status(m_st, ev_strobe, rdint_cmd);
    if (mask_wr) m_mask = mask_data;
    m_busy = f_busy(m_busy, int'(rx_level));
    #1;
  endtask

  task automatic check_all(string ts, string ti, string tb);
    chk(ts, 32'(status), 32'(m_st));
    chk(ti, 32'(irq_drive_low), 32'(|(m_st & m_mask)));
    chk(tb, 32'(rdy_drive_low), 32'(m_busy));
  endtask

  task automatic step(logic [NEV-1:0] ev, logic mw, logic [NEV-1:0] md, logic rd, int lvl);
    drive(ev, mw, md, rd, lvl);
    tick();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int lvl;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ev_strobe = '0; mask_wr = 0; mask_data = '0; rdint_cmd = 0; rx_level = '0;
    m_st = '0; m_mask = '0; m_busy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 status", 32'(status), 0);
    chk("R1 irq", 32'(irq_drive_low), 0);
    chk("R1 rdy", 32'(rdy_drive_low), 0);
    step('0, 0, '0, 0, 0);
    chk("R1 irq idle", 32'(irq_drive_low), 0);

    // R2 masked event still sets status; R6 no interrupt
    step(4'b0001, 0, '0, 0, 0);
    chk("R2 status", 32'(status), 32'h1);
    chk("R6 masked irq", 32'(irq_drive_low), 0);
    // R3 sticky over idle cycles
    repeat (5) step('0, 0, '0, 0, 0);
    chk("R3 sticky", 32'(status), 32'h1);
    // R7 unmask pending bit
    step('0, 1, 4'b0001, 0, 0);
    chk("R7 unmask irq", 32'(irq_drive_low), 1);
    // R4 read with colliding event
    drive(4'b0010, 0, '0, 1, 0);
    chk("R4 returned", 32'(status), 32'h1);
    tick();
    chk("R4 collide kept", 32'(status), 32'h2);
    chk("R6 bit1 masked", 32'(irq_drive_low), 0);
    step('0, 0, '0, 1, 0);
    chk("R4 cleared", 32'(status), 0);
    // R5 mask selects bit 2
    step('0, 1, 4'b0100, 0, 0);
    step(4'b0001, 0, '0, 0, 0);
    chk("R5 other bit", 32'(irq_drive_low), 0);
    step(4'b0100, 0, '0, 0, 0);
    chk("R5 enabled bit", 32'(irq_drive_low), 1);
    // R7 masking releases
    step('0, 1, 4'b0000, 0, 0);
    chk("R7 mask release", 32'(irq_drive_low), 0);
    chk("R3 kept", 32'(status), 32'h5);
    step('0, 0, '0, 1, 0);

    // R8 / R9 hysteresis
    step('0, 0, '0, 0, 13);
    chk("R9 free3 from ready", 32'(rdy_drive_low), 0);
    step('0, 0, '0, 0, 14);
    chk("R8 free2 busy", 32'(rdy_drive_low), 1);
    step('0, 0, '0, 0, 13);
    chk("R9 free3 hold busy", 32'(rdy_drive_low), 1);
    step('0, 0, '0, 0, 12);
    chk("R9 free4 ready", 32'(rdy_drive_low), 0);
    step('0, 0, '0, 0, 16);
    chk("R8 full busy", 32'(rdy_drive_low), 1);
    step('0, 0, '0, 0, 0);
    chk("R9 empty ready", 32'(rdy_drive_low), 0);

    // constrained random
    lvl = 8;
    for (int i = 0; i < 4000; i++) begin
      logic [NEV-1:0] ev, md;
      logic mw, rd;
      ev = (($urandom % 6) == 0) ? NEV'($urandom) : '0;
      mw = (($urandom % 15) == 0);
      md = NEV'($urandom);
      rd = (($urandom % 8) == 0);
      case ($urandom % 3)
        0: if (lvl > 0) lvl--;
        1: if (lvl < DEPTH) lvl++;
        default: ;
      endcase
      drive(ev, mw, md, rd, lvl);
      if (rd) chk("R4 returned rand", 32'(status), 32'(m_st));
      tick();
      check_all("R3 status rand", "R6 irq rand", "R8 rdy rand");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule